// File: doc/BRIEF.md
# Memory Test Access Port

This block is the serial test logic of a synchronous memory. A five-wire access port (clock, mode select, serial in, serial out, optional asynchronous reset) drives a sixteen-state controller. The controller moves a three-bit instruction in and out and selects one of three data paths between the serial input and output:
- a one-bit pass-through stage,
- a fixed 32-bit identity word,
- a boundary chain that snapshots the memory's pins.

Two instruction codes take a snapshot while the data pins are held off the bus, so that the captured inputs do not depend on what the memory itself is doing. One code takes a snapshot with the pins left alone. One code returns the identity word. The remaining codes behave as the pass-through stage. A single parameter picks between a narrow (18 data bit) and a wide (36 data bit) memory organisation. It sets the length of the boundary chain and the contents of the identity word. Serial output is launched on the falling test clock and is driven only while a shift state is active.

Top module: `sramTapTop`

## Requirements
- R1: Holding trstN low, or entering Test-Logic-Reset, makes the active instruction 001 (identity). It also drives tdoOe and dqHighZ low.
- R2: The controller follows the standard sixteen-state transition graph on the rising test clock. Five clocks with tms high reach Test-Logic-Reset from any state. The pause states resume shifting without a new capture.
- R3: Capture-IR loads 001 into the instruction shifter. The instruction shifts out least significant bit first, with tdi entering the most significant of its three bits.
- R4: A shifted instruction becomes active on the clock that leaves Update-IR, and at no other time except reset. The decode is as follows:
  - 000 and 010: snapshot with the pins held off (boundary chain).
  - 001: identity word.
  - 100: snapshot with the pins live (boundary chain).
  - 011, 101, 110 and 111: pass-through stage.
- R5: Under 001, Shift-DR returns 32 bits least significant first:
  - bits 31:28 are 0001;
  - bits 27:18 are 1000000110 (narrow) or 0111001101 (wide);
  - bits 17:12 are 000001 (narrow) or 100001 (wide);
  - bits 11:1 are 00010111111;
  - bit 0 is 1.
- R6: The pass-through stage captures 0 in Capture-DR and delays tdi by exactly one shift. After leaving Shift-DR it keeps the last bit shifted in, and that bit appears first when shifting resumes through Pause-DR.
- R7: The boundary chain is 51 cells (narrow) or 70 cells (wide) long. Cell 0 is nearest tdo. The cells hold, from cell 0 upward:
  - the data inputs;
  - the address inputs (16 narrow, 15 wide);
  - the byte-write inputs (2 narrow, 4 wide);
  - nine control/clock inputs;
  - six placeholders that capture 0.
- R8: dqHighZ is high exactly while the active instruction is 000 or 010.
- R9: tdo changes only on the falling test clock. tdoOe is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising test clock |
| tdi | input | 1 | Serial data in |
| trstN | input | 1 | Asynchronous test reset, active low |
| pinData | input | 18 / 36 | Data input pins seen by the boundary cells |
| pinAddr | input | 16 / 15 | Address pins seen by the boundary cells |
| pinBw | input | 2 / 4 | Byte-write pins seen by the boundary cells |
| pinCtrl | input | 9 | Control pins; bit 0 is the single-ended internal clock |
| tdo | output | 1 | Serial data out, valid while tdoOe is high |
| tdoOe | output | 1 | Output enable for tdo |
| dqHighZ | output | 1 | Holds the memory data pins at high impedance |

## Verification
A controller stuck in the wrong state shows up within one clock as a misplaced tdoOe window, and within a few clocks as a missing or extra capture in the serial stream. A wrong active instruction shows on dqHighZ as soon as Update-IR is left. On the next data shift it also shows as the wrong first bit: 1 for identity, 0 for pass-through, data bit 0 for the chain. A wrong chain length or cell order misplaces the tdi marker bits that follow the captured word, so the error is visible at a known shift count for both organisations.

// File: rtl/scanPkg.sv
package scanPkg;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tapStateT;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} pathSelT;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] IR_ID      = 3'b001;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
  localparam logic [IR_W-1:0] IR_SNAP    = 3'b100;

  typedef struct packed {
    logic    capDr;
    logic    shDr;
    logic    shIr;
    logic    clrByp;
    pathSelT path;
    logic    hiZ;
  } ctrlStrobeT;

  function automatic logic [31:0] idWord(input bit wide36);
    logic [9:0] dens;
    logic [5:0] vend;
    dens = wide36 ? 10'b0111001101 : 10'b1000000110;
    vend = wide36 ? 6'b100001 : 6'b000001;
    return {4'b0001, dens, vend, 11'b00010111111, 1'b1};
  endfunction

  function automatic pathSelT pathOf(input logic [IR_W-1:0] code);
    case (code)
      3'b000, 3'b010, 3'b100: return PATH_BSR;
      3'b001:                 return PATH_ID;
      default:                return PATH_BYP;
    endcase
  endfunction

  function automatic logic floatsPins(input logic [IR_W-1:0] code);
    return (code == 3'b000) || (code == 3'b010);
  endfunction

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
(
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output ctrlStrobeT       strb,
  output logic             irOut,
  output tapStateT         tapState,
  output logic [IR_W-1:0]  instrCode
);

  tapStateT nextState;
  logic [IR_W-1:0] irShift;

  always_comb begin
    nextState = tapState;
    case (tapState)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SH_DR;
      SH_DR:  nextState = tms ? EX1_DR : SH_DR;
      EX1_DR: nextState = tms ? UPD_DR : PA_DR;
      PA_DR:  nextState = tms ? EX2_DR : PA_DR;
      EX2_DR: nextState = tms ? UPD_DR : SH_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SH_IR;
      SH_IR:  nextState = tms ? EX1_IR : SH_IR;
      EX1_IR: nextState = tms ? UPD_IR : PA_IR;
      PA_IR:  nextState = tms ? EX2_IR : PA_IR;
      EX2_IR: nextState = tms ? UPD_IR : SH_IR;
      UPD_IR: nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TLR;
    else        tapState <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
    end else if (tapState == CAP_IR) begin
      irShift <= IR_CAPTURE;
    end else if (tapState == SH_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                 instrCode <= IR_ID;
    else if (nextState == TLR)  instrCode <= IR_ID;
    else if (tapState == UPD_IR) instrCode <= irShift;
  end

  assign irOut = irShift[0];

  always_comb begin
    strb.capDr  = (tapState == CAP_DR);
    strb.shDr   = (tapState == SH_DR);
    strb.shIr   = (tapState == SH_IR);
    strb.clrByp = (tapState == UPD_IR) && (pathOf(irShift) == PATH_BYP);
    strb.path   = pathOf(instrCode);
    strb.hiZ    = floatsPins(instrCode);
  end

endmodule

// File: rtl/scanPath.sv
module scanPath
  import scanPkg::*;
#(
  parameter int          DATA_W  = 18,
  parameter int          ADDR_W  = 16,
  parameter int          BW_W    = 2,
  parameter int          CTRL_W  = 9,
  parameter int          PAD_W   = 6,
  parameter logic [31:0] ID_WORD = 32'h1
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  ctrlStrobeT        strb,
  input  logic              irOut,
  input  logic [DATA_W-1:0] pinData,
  input  logic [ADDR_W-1:0] pinAddr,
  input  logic [BW_W-1:0]   pinBw,
  input  logic [CTRL_W-1:0] pinCtrl,
  output logic              tdo,
  output logic              tdoOe
);

  localparam int CHAIN_LEN = DATA_W + ADDR_W + BW_W + CTRL_W + PAD_W;

  logic                 bypassBit;
  logic [31:0]          idShift;
  logic [CHAIN_LEN-1:0] chain;
  logic [CHAIN_LEN-1:0] chainNext;
  logic [CHAIN_LEN-1:0] snapVec;
  logic                 dataOut;
  logic                 chainShift;

  assign snapVec    = {{PAD_W{1'b0}}, pinCtrl, pinBw, pinAddr, pinData};
  assign chainShift = strb.shDr && (strb.path == PATH_BSR);

  generate
    for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_cell
      logic serialIn;
      if (c == CHAIN_LEN - 1) begin : g_head
        assign serialIn = tdi;
      end else begin : g_body
        assign serialIn = chain[c+1];
      end
      assign chainNext[c] = strb.capDr ? snapVec[c]
                          : chainShift ? serialIn
                          : chain[c];
    end
  endgenerate

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) chain <= '0;
    else        chain <= chainNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
    end else if (strb.capDr || strb.clrByp) begin
      bypassBit <= 1'b0;
    end else if (strb.shDr && strb.path == PATH_BYP) begin
      bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= ID_WORD;
    end else if (strb.capDr) begin
      idShift <= ID_WORD;
    end else if (strb.shDr && strb.path == PATH_ID) begin
      idShift <= {tdi, idShift[31:1]};
    end
  end

  always_comb begin
    case (strb.path)
      PATH_ID:  dataOut = idShift[0];
      PATH_BSR: dataOut = chain[0];
      default:  dataOut = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= strb.shIr ? irOut : dataOut;
      tdoOe <= strb.shIr || strb.shDr;
    end
  end

endmodule

// File: rtl/sramTapTop.sv
module sramTapTop
  import scanPkg::*;
#(
  parameter bit WIDE36 = 1'b0,
  localparam int DATA_W = WIDE36 ? 36 : 18,
  localparam int ADDR_W = WIDE36 ? 15 : 16,
  localparam int BW_W   = WIDE36 ? 4 : 2,
  localparam int CTRL_W = 9
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trstN,
  input  logic [DATA_W-1:0] pinData,
  input  logic [ADDR_W-1:0] pinAddr,
  input  logic [BW_W-1:0]   pinBw,
  input  logic [CTRL_W-1:0] pinCtrl,
  output logic              tdo,
  output logic              tdoOe,
  output logic              dqHighZ
);

  localparam int PAD_W = 6;

  ctrlStrobeT      strb;
  logic            irOut;
  tapStateT        tapState;
  logic [IR_W-1:0] instrCode;

  scanCtrl u_ctrl (
    .tck       (tck),
    .trstN     (trstN),
    .tms       (tms),
    .tdi       (tdi),
    .strb      (strb),
    .irOut     (irOut),
    .tapState  (tapState),
    .instrCode (instrCode)
  );

  scanPath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .BW_W    (BW_W),
    .CTRL_W  (CTRL_W),
    .PAD_W   (PAD_W),
    .ID_WORD (idWord(WIDE36))
  ) u_path (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .strb    (strb),
    .irOut   (irOut),
    .pinData (pinData),
    .pinAddr (pinAddr),
    .pinBw   (pinBw),
    .pinCtrl (pinCtrl),
    .tdo     (tdo),
    .tdoOe   (tdoOe)
  );

  assign dqHighZ = strb.hiZ;

endmodule

// File: rtl/sramTapCheck.sv
module sramTapCheck
  import scanPkg::*;
(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdoOe,
  input logic            dqHighZ,
  input tapStateT        tapState,
  input logic [IR_W-1:0] instrCode
);

  // R9: output enable only inside a shift state
  p_oe_shift_only_r9: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe |-> (tapState == SH_DR || tapState == SH_IR));

  // R9: leaving Shift-DR drops the enable by the next rising edge
  p_oe_drop_r9: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == SH_DR && tms) |=> !tdoOe);

  // R1: reset state always holds the identity instruction
  p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TLR) |-> (instrCode == IR_ID && !dqHighZ));

  // R2: reset state is sticky while tms stays high
  p_tlr_hold_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TLR && tms) |=> (tapState == TLR));

  // R2: Update-DR with tms low returns to idle
  p_upd_dr_exit_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == UPD_DR && !tms) |=> (tapState == RTI));

  // R4: instruction changes only out of Update-IR or into reset
  p_instr_change_r4: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(instrCode) |-> ($past(tapState) == UPD_IR || tapState == TLR));

  // R8: pin float request begins only when an instruction takes effect
  p_hiz_rise_r8: assert property (@(posedge tck) disable iff (!trstN)
    $rose(dqHighZ) |-> ($past(tapState) == UPD_IR));

endmodule

bind sramTapTop sramTapCheck u_check (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .tdoOe     (tdoOe),
  .dqHighZ   (dqHighZ),
  .tapState  (tapState),
  .instrCode (instrCode)
);

// File: tb/sramTapTop_bench.sv
`timescale 1ns/1ps
module sramTapTop_bench;

  logic tck = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic trstN = 1'b0;

  logic [17:0] dA;
  logic [15:0] aA;
  logic [1:0]  bA;
  logic [8:0]  cA;
  logic [35:0] dB;
  logic [14:0] aB;
  logic [3:0]  bB;
  logic [8:0]  cB;

  logic tdoA, oeA, hzA, tdoB, oeB, hzB;

  int total = 0;
  int bad = 0;
  int edgeBad = 0;
  int oeBad = 0;
  logic smpA, smpB, smpOeA, smpOeB;

  always #5 tck = ~tck;

  sramTapTop #(.WIDE36(1'b0)) u_sramTapTop (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .pinData(dA), .pinAddr(aA), .pinBw(bA), .pinCtrl(cA),
    .tdo(tdoA), .tdoOe(oeA), .dqHighZ(hzA));

  sramTapTop #(.WIDE36(1'b1)) u_sramTapTop36 (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .pinData(dB), .pinAddr(aB), .pinBw(bB), .pinCtrl(cB),
    .tdo(tdoB), .tdoOe(oeB), .dqHighZ(hzB));

  localparam logic [31:0] ID_A = {4'b0001, 10'b1000000110, 6'b000001, 11'b00010111111, 1'b1};
  localparam logic [31:0] ID_B = {4'b0001, 10'b0111001101, 6'b100001, 11'b00010111111, 1'b1};

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one TCK: drive after falling edge, sample tdo, check it holds across the rising edge (R9)
  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    smpA = tdoA; smpB = tdoB; smpOeA = oeA; smpOeB = oeB;
    @(posedge tck); #1;
    if (tdoA !== smpA || tdoB !== smpB) edgeBad++;
  endtask

  // from idle: load an instruction, return captured bits (R3), optional pause in the middle (R2)
  task automatic loadIr(input logic [2:0] code, input bit viaPause,
                        output logic [2:0] capA, output logic [2:0] capB);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step((i == 2) || (viaPause && i == 0), code[i]);
      capA[i] = smpA; capB[i] = smpB;
      if (viaPause && i == 0) begin
        step(0, 0); step(1, 0); step(0, 0);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  // from idle: capture and shift n data bits, back to idle
  task automatic drShift(input int n, input logic [127:0] din,
                         output logic [127:0] oA, output logic [127:0] oB);
    oA = '0; oB = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      oA[i] = smpA; oB[i] = smpB;
      if (!smpOeA || !smpOeB) oeBad++;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic checkChain(input string tag, input logic [127:0] din);
    logic [127:0] oA, oB, vA, vB, mask;
    vA = {6'b0, cA, bA, aA, dA};
    vB = {6'b0, cB, bB, aB, dB};
    mask = (128'd1 << 78) - 1;
    drShift(78, din, oA, oB);
    chk({tag, " x18"}, oA & mask, (vA | (din << 51)) & mask);
    chk({tag, " x36"}, oB & mask, (vB | (din << 70)) & mask);
  endtask

  logic done = 1'b0;

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] oA, oB, din;
    logic [2:0] cpA, cpB;
    dA = '0; aA = '0; bA = '0; cA = '0;
    dB = '0; aB = '0; bB = '0; cB = '0;

    repeat (3) @(posedge tck);
    #2;
    chk("R1 reset oe", {oeA, oeB}, 2'b00);
    chk("R1 reset hz", {hzA, hzB}, 2'b00);
    @(negedge tck); #1; trstN = 1'b1;
    step(0, 0);

    // R5 / R1: identity after reset
    drShift(32, '0, oA, oB);
    chk("R5 id x18", oA[31:0], ID_A);
    chk("R5 id x36", oB[31:0], ID_B);
    chk("R9 oe idle", {oeA, oeB}, 2'b00);

    // R3: instruction capture pattern, with pause path (R2)
    loadIr(3'b111, 1'b0, cpA, cpB);
    chk("R3 ir capture", {cpA, cpB}, {3'b001, 3'b001});
    loadIr(3'b111, 1'b1, cpA, cpB);
    chk("R2 ir capture via pause", {cpA, cpB}, {3'b001, 3'b001});

    // R6: one-shift delay, captured 0 first
    din = 128'h2CB;  // 10 bits, top bit 1
    drShift(10, din, oA, oB);
    chk("R6 bypass delay x18", oA[9:0], {din[8:0], 1'b0});
    chk("R6 bypass delay x36", oB[9:0], {din[8:0], 1'b0});

    // R6: hold after Shift-DR, resumed through Pause-DR
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, 1'b1);
    step(0, 0); step(1, 0); step(0, 0);
    step(1, 0);
    chk("R6 bypass hold", {smpA, smpB}, 2'b11);
    step(1, 0); step(0, 0);

    // R4 / R8: sweep every code
    for (int k = 0; k < 8; k++) begin
      logic [2:0] code;
      logic expHz;
      code = k[2:0];
      expHz = (code == 3'b000) || (code == 3'b010);
      loadIr(code, 1'b0, cpA, cpB);
      chk($sformatf("R8 hz code %0d", k), {hzA, hzB}, {expHz, expHz});
      if (code == 3'b001) begin
        drShift(32, '0, oA, oB);
        chk("R4 code 1 selects id", {oA[31:0], oB[31:0]}, {ID_A, ID_B});
      end else if (code == 3'b000 || code == 3'b010 || code == 3'b100) begin
        dA = 18'h2A5C3 ^ (k * 18'h1111); aA = 16'hB00F ^ k[15:0];
        bA = 2'b10; cA = 9'h15A;
        dB = 36'hC_3A5F_0E17 ^ (k * 36'h1_0101); aB = 15'h5A3C;
        bB = 4'b0110; cB = 9'h0A7 ^ k[8:0];
        checkChain($sformatf("R7 chain code %0d", k), 128'hD5 ^ (k << 3));
      end else begin
        drShift(6, 128'h25, oA, oB);
        chk($sformatf("R4 code %0d bypass", k), {oA[5:0], oB[5:0]}, {6'h0A, 6'h0A});
      end
    end

    // R7: all-ones pins show the placeholders as zeros
    loadIr(3'b100, 1'b0, cpA, cpB);
    dA = '1; aA = '1; bA = '1; cA = '1; dB = '1; aB = '1; bB = '1; cB = '1;
    checkChain("R7 chain ones", 128'h0);

    // R1 / R2: five tms-high clocks from a floating instruction
    loadIr(3'b010, 1'b0, cpA, cpB);
    chk("R8 hz before reset", {hzA, hzB}, 2'b11);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 tms reset hz", {hzA, hzB}, 2'b00);
    step(0, 0);
    drShift(32, '0, oA, oB);
    chk("R2 tms reset id", {oA[31:0], oB[31:0]}, {ID_A, ID_B});

    // R1: asynchronous reset
    loadIr(3'b000, 1'b0, cpA, cpB);
    @(negedge tck); #1; trstN = 1'b0; #2;
    chk("R1 trst hz", {hzA, hzB}, 2'b00);
    chk("R1 trst oe", {oeA, oeB}, 2'b00);
    @(negedge tck); #1; trstN = 1'b1;
    step(0, 0);
    drShift(32, '0, oA, oB);
    chk("R1 trst id", {oA[31:0], oB[31:0]}, {ID_A, ID_B});

    chk("R9 tdo falling edge only", edgeBad, 0);
    chk("R9 oe during shift", oeBad, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule